// File: doc/BRIEF.md
# Multi-Mode Gated Timer/Counter

This block is one timer/counter channel. In timer operation it advances on a machine-cycle strobe, which arrives once every twelve oscillator periods. In counter operation it advances on an event strobe that marks an already-qualified falling edge on an external pin. Counting is allowed only while the run bit is set, and the gate option can make it also depend on an external gate pin, which lets software measure the width of a pulse.

A two-bit mode field selects how the high and low bytes are combined:
- a 13-bit counter made of the full high byte and a prescaler held in the low bits of the low byte;
- a plain 16-bit counter;
- an 8-bit counter in the low byte that reloads from the high byte;
- a split arrangement in which the high byte runs as an independent 8-bit timer with its own run input and its own overflow flag.

Both bytes can be loaded through a write port. The overflow flags stay set until software clears them.

Top module: `gtc_unit`

## Requirements
- R1: After reset both count bytes read 0x00 and both overflow flags read 0.
- R2: The main counter advances only in a cycle where run_i=1 and either gate_en_i=0 or gate_pin_i=1. Its source is tick_i when sel_event_i=0 and event_i when sel_event_i=1. In any other cycle, and with no write, the count holds.
- R3: Raising run_i leaves the count bytes unchanged. Counting resumes from the value held.
- R4: With mode_i=2'b00, the low PRE_W bits of the low byte form a prescaler (bits 4:0 by default). The prescaler carries into the high byte. The low-byte bits above the prescaler hold their value. When the 13-bit value wraps from all ones to zero, ovf_o is set.
- R5: With mode_i=2'b01, {cnt_hi_o,cnt_lo_o} is a 16-bit up-counter. When it wraps from 0xFFFF to 0x0000, ovf_o is set.
- R6: With mode_i=2'b10, only the low byte counts. When it passes 0xFF it is loaded from the high byte and ovf_o is set. The high byte never changes in this mode except by a write.
- R7: With mode_i=2'b11, the low byte is an 8-bit counter under the main control of R2 and sets ovf_o when it wraps. The high byte counts tick_i whenever run_hi_i=1 and sets ovf_hi_o when it wraps from 0xFF. In the other modes run_hi_i has no effect and ovf_hi_o holds.
- R8: Each overflow flag stays at 1 until its clear input (clr_ovf_i or clr_ovf_hi_i) is pulsed. If a clear and a new overflow fall in the same cycle, the flag ends that cycle set.
- R9: wr_lo_i loads wr_data_i into the low byte and wr_hi_i loads it into the high byte. In modes 0 to 2, a cycle with either write performs no increment and no overflow. In mode 3, a write cancels only the increment of the counter it loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle strobe |
| event_i | input | 1 | Qualified external falling-edge strobe |
| sel_event_i | input | 1 | 1 selects event counting, 0 selects timer ticks |
| run_i | input | 1 | Run bit for the main counter |
| gate_en_i | input | 1 | When 1, counting also needs gate_pin_i high |
| gate_pin_i | input | 1 | External gate level |
| mode_i | input | 2 | Layout select (00 13-bit, 01 16-bit, 10 reload, 11 split) |
| run_hi_i | input | 1 | Run bit of the high-byte timer in split mode |
| wr_lo_i | input | 1 | Load low byte |
| wr_hi_i | input | 1 | Load high byte |
| wr_data_i | input | BYTE_W | Write data |
| clr_ovf_i | input | 1 | Clear main overflow flag |
| clr_ovf_hi_i | input | 1 | Clear split high-byte overflow flag |
| cnt_lo_o | output | BYTE_W | Low count byte |
| cnt_hi_o | output | BYTE_W | High count byte |
| ovf_o | output | 1 | Sticky main overflow flag |
| ovf_hi_o | output | 1 | Sticky high-byte overflow flag (split mode) |

## Verification
The bound checker watches several properties on every cycle:
- the count is frozen while the main counter is disabled and nothing is written;
- write data lands in the addressed byte;
- the reload source stays fixed in reload mode;
- the prescaler's upper bits stay frozen in 13-bit mode;
- the split timer and its flag stay idle while they are not enabled;
- the flags stay sticky until cleared.

The exact wrap points remain for the bench's scenarios. These are the 0x1FFF and 0xFFFF rollovers, the reload value after 0xFF, and the set-wins rule when a clear and an overflow meet. The bench checks them against its behavioural model, which covers preloaded corner values, gate and source changes, and a long run of random traffic in all four modes.

// File: rtl/gtc_pkg.sv
package gtc_pkg;
   typedef enum logic [1:0] {
      GTC_M13    = 2'b00,
      GTC_M16    = 2'b01,
      GTC_RELOAD = 2'b10,
      GTC_SPLIT  = 2'b11
   } gtc_mode_e;
endpackage

// File: rtl/gtc_enable.sv
// Qualifies the count sources with run and gate control.
module gtc_enable (
   input  logic tick_i,
   input  logic event_i,
   input  logic sel_event_i,
   input  logic run_i,
   input  logic gate_en_i,
   input  logic gate_pin_i,
   input  logic run_hi_i,
   output logic main_inc_o,
   output logic hi_inc_o
);
   logic gate_ok;
   logic src;

   always_comb begin
      gate_ok    = !gate_en_i || gate_pin_i;
      src        = sel_event_i ? event_i : tick_i;
      main_inc_o = run_i && gate_ok && src;
      // the split high-byte timer always counts machine cycles, ungated
      hi_inc_o   = run_hi_i && tick_i;
   end
endmodule

// File: rtl/gtc_core.sv
// Next-state arithmetic for the four layouts.
module gtc_core
   import gtc_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input  gtc_mode_e         mode_i,
   input  logic [BYTE_W-1:0] lo_i,
   input  logic [BYTE_W-1:0] hi_i,
   input  logic              main_go_i,
   input  logic              hi_go_i,
   output logic [BYTE_W-1:0] lo_nxt_o,
   output logic [BYTE_W-1:0] hi_nxt_o,
   output logic              main_wrap_o,
   output logic              hi_wrap_o
);
   localparam int WIDE_W = 2 * BYTE_W;
   localparam logic [BYTE_W-1:0] ONES = {BYTE_W{1'b1}};

   logic [BYTE_W-1:0] pre_mask;

   generate
      if (PRE_W == BYTE_W) begin : g_pre_full
         assign pre_mask = ONES;
      end else begin : g_pre_part
         assign pre_mask = {{(BYTE_W-PRE_W){1'b0}}, {PRE_W{1'b1}}};
      end
   endgenerate

   logic [WIDE_W-1:0] wide_inc;
   logic [BYTE_W-1:0] lo_inc;
   logic [BYTE_W-1:0] hi_inc;
   logic              pre_full;

   always_comb begin
      wide_inc = {hi_i, lo_i} + WIDE_W'(1);
      lo_inc   = lo_i + BYTE_W'(1);
      hi_inc   = hi_i + BYTE_W'(1);
      pre_full = (lo_i & pre_mask) == pre_mask;
   end

   always_comb begin
      lo_nxt_o    = lo_i;
      hi_nxt_o    = hi_i;
      main_wrap_o = 1'b0;
      hi_wrap_o   = 1'b0;
      unique case (mode_i)
         GTC_M13: begin
            if (main_go_i) begin
               lo_nxt_o = (lo_i & ~pre_mask) | (lo_inc & pre_mask);
               if (pre_full) begin
                  hi_nxt_o    = hi_inc;
                  main_wrap_o = (hi_i == ONES);
               end
            end
         end
         GTC_M16: begin
            if (main_go_i) begin
               {hi_nxt_o, lo_nxt_o} = wide_inc;
               main_wrap_o          = ({hi_i, lo_i} == {WIDE_W{1'b1}});
            end
         end
         GTC_RELOAD: begin
            if (main_go_i) begin
               if (lo_i == ONES) begin
                  lo_nxt_o    = hi_i;
                  main_wrap_o = 1'b1;
               end else begin
                  lo_nxt_o = lo_inc;
               end
            end
         end
         GTC_SPLIT: begin
            if (main_go_i) begin
               lo_nxt_o    = lo_inc;
               main_wrap_o = (lo_i == ONES);
            end
            if (hi_go_i) begin
               hi_nxt_o  = hi_inc;
               hi_wrap_o = (hi_i == ONES);
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/gtc_sticky.sv
// Sticky flag; SET_WINS picks the priority when set and clear coincide.
module gtc_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_o <= 1'b0;
            else        flag_o <= set_i || (flag_o && !clr_i);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_o <= 1'b0;
            else        flag_o <= !clr_i && (flag_o || set_i);
         end
      end
   endgenerate
endmodule

// File: rtl/gtc_unit.sv
// Multi-mode gated timer/counter channel.
module gtc_unit
   import gtc_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int PRE_W         = 5,
   parameter bit FLAG_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              event_i,
   input  logic              sel_event_i,
   input  logic              run_i,
   input  logic              gate_en_i,
   input  logic              gate_pin_i,
   input  logic [1:0]        mode_i,
   input  logic              run_hi_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              clr_ovf_i,
   input  logic              clr_ovf_hi_i,
   output logic [BYTE_W-1:0] cnt_lo_o,
   output logic [BYTE_W-1:0] cnt_hi_o,
   output logic              ovf_o,
   output logic              ovf_hi_o
);
   localparam int N_FLAGS = 2;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("gtc_unit: BYTE_W must be at least 2");
      end
      if (PRE_W < 1 || PRE_W > BYTE_W) begin : g_bad_pre
         $error("gtc_unit: PRE_W must lie in 1..BYTE_W");
      end
   endgenerate

   gtc_mode_e         mode;
   logic              main_inc, hi_inc;
   logic              main_go, hi_go;
   logic              split;
   logic [BYTE_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
   logic              main_wrap, hi_wrap;
   logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

   assign mode = gtc_mode_e'(mode_i);

   gtc_enable i_enable (
      .tick_i      (tick_i),
      .event_i     (event_i),
      .sel_event_i (sel_event_i),
      .run_i       (run_i),
      .gate_en_i   (gate_en_i),
      .gate_pin_i  (gate_pin_i),
      .run_hi_i    (run_hi_i),
      .main_inc_o  (main_inc),
      .hi_inc_o    (hi_inc)
   );

   // writes win over increments; in split mode each byte is its own counter
   always_comb begin
      split   = (mode == GTC_SPLIT);
      main_go = main_inc && (split ? !wr_lo_i : !(wr_lo_i || wr_hi_i));
      hi_go   = split && hi_inc && !wr_hi_i;
   end

   gtc_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) i_core (
      .mode_i      (mode),
      .lo_i        (lo_q),
      .hi_i        (hi_q),
      .main_go_i   (main_go),
      .hi_go_i     (hi_go),
      .lo_nxt_o    (lo_nxt),
      .hi_nxt_o    (hi_nxt),
      .main_wrap_o (main_wrap),
      .hi_wrap_o   (hi_wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= wr_lo_i ? wr_data_i : lo_nxt;
         hi_q <= wr_hi_i ? wr_data_i : hi_nxt;
      end
   end

   assign flag_set = {hi_wrap, main_wrap};
   assign flag_clr = {clr_ovf_hi_i, clr_ovf_i};

   generate
      for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
         gtc_sticky #(.SET_WINS(FLAG_SET_WINS)) i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (flag_set[f]),
            .clr_i  (flag_clr[f]),
            .flag_o (flag_q[f])
         );
      end
   endgenerate

   assign cnt_lo_o = lo_q;
   assign cnt_hi_o = hi_q;
   assign ovf_o    = flag_q[0];
   assign ovf_hi_o = flag_q[1];
endmodule

// File: rtl/gtc_unit_chk.sv
module gtc_unit_chk #(
   parameter int BYTE_W = 8,
   parameter int PRE_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_i,
   input logic [1:0]        mode_i,
   input logic              run_hi_i,
   input logic              wr_lo_i,
   input logic              wr_hi_i,
   input logic [BYTE_W-1:0] wr_data_i,
   input logic              clr_ovf_i,
   input logic              clr_ovf_hi_i,
   input logic [BYTE_W-1:0] cnt_lo_o,
   input logic [BYTE_W-1:0] cnt_hi_o,
   input logic              ovf_o,
   input logic              ovf_hi_o
);
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_lo_i && !wr_hi_i && mode_i != 2'b11)
      |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o))); // R2

   AST_WRITE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> (cnt_lo_o == $past(wr_data_i))); // R9

   AST_WRITE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi_i |=> (cnt_hi_o == $past(wr_data_i))); // R9

   AST_RELOAD_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b10 && !wr_hi_i) |=> $stable(cnt_hi_o)); // R6

   AST_PRESCALE_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00 && !wr_lo_i)
      |=> ((cnt_lo_o >> PRE_W) == ($past(cnt_lo_o) >> PRE_W))); // R4

   AST_SPLIT_HI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b11 && !run_hi_i && !wr_hi_i) |=> $stable(cnt_hi_o)); // R7

   AST_HI_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b11 && !clr_ovf_hi_i) |=> $stable(ovf_hi_o)); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_ovf_i) |=> ovf_o); // R8

   AST_HI_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_hi_o && !clr_ovf_hi_i) |=> ovf_hi_o); // R8
endmodule

bind gtc_unit gtc_unit_chk #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) i_gtc_unit_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_i        (run_i),
   .mode_i       (mode_i),
   .run_hi_i     (run_hi_i),
   .wr_lo_i      (wr_lo_i),
   .wr_hi_i      (wr_hi_i),
   .wr_data_i    (wr_data_i),
   .clr_ovf_i    (clr_ovf_i),
   .clr_ovf_hi_i (clr_ovf_hi_i),
   .cnt_lo_o     (cnt_lo_o),
   .cnt_hi_o     (cnt_hi_o),
   .ovf_o        (ovf_o),
   .ovf_hi_o     (ovf_hi_o)
);

// File: tb/test_gtc_unit.sv
module test_gtc_unit;
   localparam int CLK_PERIOD = 10;
   localparam int BW   = 8;
   localparam int PRE  = 5;
   localparam int BMOD = 1 << BW;
   localparam int PMOD = 1 << PRE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick, ev, sel_ev, run, gate_en, gate_pin, run_hi;
   logic [1:0] mode;
   logic wr_lo, wr_hi, clr, clr_hi;
   logic [BW-1:0] wdata;
   logic [BW-1:0] cnt_lo, cnt_hi;
   logic ovf, ovf_hi;

   int checks = 0;
   int fails  = 0;
   int m_lo = 0, m_hi = 0, m_ovf = 0, m_ovfh = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gtc_unit i_gtc_unit (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .event_i(ev),
      .sel_event_i(sel_ev), .run_i(run), .gate_en_i(gate_en),
      .gate_pin_i(gate_pin), .mode_i(mode), .run_hi_i(run_hi),
      .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wdata),
      .clr_ovf_i(clr), .clr_ovf_hi_i(clr_hi),
      .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .ovf_o(ovf), .ovf_hi_o(ovf_hi)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, "cnt_lo", int'(cnt_lo), m_lo);
      check(tag, "cnt_hi", int'(cnt_hi), m_hi);
      check(tag, "ovf", int'(ovf), m_ovf);
      check(tag, "ovf_hi", int'(ovf_hi), m_ovfh);
   endtask

   // behavioural reference for one clock, using the inputs now applied
   task automatic model_step();
      bit en, hen, set, seth, sp;
      int v;
      sp  = (mode == 2'd3);
      en  = run && (!gate_en || gate_pin) && (sel_ev ? ev : tick);
      if (sp) en = en && !wr_lo;
      else    en = en && !wr_lo && !wr_hi;
      hen = sp && run_hi && tick && !wr_hi;
      set = 0; seth = 0;
      case (mode)
         2'd0: if (en) begin
            v = m_hi * PMOD + (m_lo % PMOD) + 1;
            if (v == BMOD * PMOD) begin v = 0; set = 1; end
            m_hi = v / PMOD;
            m_lo = (m_lo / PMOD) * PMOD + (v % PMOD);
         end
         2'd1: if (en) begin
            v = m_hi * BMOD + m_lo + 1;
            if (v == BMOD * BMOD) begin v = 0; set = 1; end
            m_hi = v / BMOD; m_lo = v % BMOD;
         end
         2'd2: if (en) begin
            if (m_lo == BMOD - 1) begin m_lo = m_hi; set = 1; end
            else m_lo = m_lo + 1;
         end
         default: begin
            if (en) begin
               if (m_lo == BMOD - 1) begin m_lo = 0; set = 1; end
               else m_lo = m_lo + 1;
            end
            if (hen) begin
               if (m_hi == BMOD - 1) begin m_hi = 0; seth = 1; end
               else m_hi = m_hi + 1;
            end
         end
      endcase
      if (wr_lo) m_lo = int'(wdata);
      if (wr_hi) m_hi = int'(wdata);
      m_ovf  = set  ? 1 : (clr    ? 0 : m_ovf);
      m_ovfh = seth ? 1 : (clr_hi ? 0 : m_ovfh);
   endtask

   task automatic idle();
      tick = 0; ev = 0; wr_lo = 0; wr_hi = 0; clr = 0; clr_hi = 0;
   endtask

   task automatic cyc(input string tag);
      model_step();
      @(negedge clk);
      compare(tag);
      idle();
   endtask

   task automatic load(input string tag, input int hi, input int lo);
      wr_hi = 1; wr_lo = 1; wdata = BW'(lo);
      // both writes share the data bus: load low, then high
      wr_hi = 0; cyc(tag);
      wr_hi = 1; wdata = BW'(hi); cyc(tag);
   endtask

   task automatic ticks(input string tag, input int n);
      for (int i = 0; i < n; i++) begin tick = 1; cyc(tag); end
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      idle();
      sel_ev = 0; run = 0; gate_en = 0; gate_pin = 0; run_hi = 0;
      mode = 2'd1; wdata = '0;
      repeat (3) @(negedge clk);
      compare("R1");                       // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R2: run, gate and source selection
      ticks("R2", 3);                      // run=0: hold
      run = 1; ticks("R2", 4);
      gate_en = 1; gate_pin = 0; ticks("R2", 3);
      gate_pin = 1; ticks("R2", 3);
      sel_ev = 1;
      for (int i = 0; i < 6; i++) begin tick = 1; ev = (i % 2 == 0); cyc("R2"); end
      sel_ev = 0; gate_en = 0;

      // R3: stop, then start again without clearing
      run = 0; ticks("R3", 2);
      run = 1; ticks("R3", 3);

      // R9: write beats increment
      wr_lo = 1; wdata = 8'h5A; tick = 1; cyc("R9");
      wr_hi = 1; wdata = 8'hC3; tick = 1; cyc("R9");
      ticks("R9", 2);

      // R4: 13-bit mode wrap, upper low-byte bits kept
      mode = 2'd0; run = 0;
      load("R4", 8'hFF, 8'hFC);
      run = 1; ticks("R4", 5);
      clr = 1; cyc("R4");

      // R5: 16-bit wrap
      mode = 2'd1; run = 0;
      load("R5", 8'hFF, 8'hFD);
      run = 1; ticks("R5", 5);

      // R8: set wins over clear, then clear
      load("R8", 8'hFF, 8'hFF);
      tick = 1; clr = 1; cyc("R8");
      ticks("R8", 2);
      clr = 1; cyc("R8");

      // R6: reload from high byte
      mode = 2'd2; run = 0;
      load("R6", 8'hF0, 8'hFD);
      run = 1; ticks("R6", 20);
      clr = 1; cyc("R6");

      // R7: split mode and run_hi ignored elsewhere
      mode = 2'd1; run = 0; run_hi = 1; ticks("R7", 4);
      mode = 2'd3;
      load("R7", 8'hFE, 8'hFE);
      run = 1; ticks("R7", 4);
      run = 0; ticks("R7", 3);
      run_hi = 0; run = 1; ticks("R7", 3);
      clr_hi = 1; cyc("R7");

      // random traffic across all modes
      for (int i = 0; i < 3000; i++) begin
         if (i % 200 == 0) mode = 2'($urandom_range(0, 3));
         tick     = 1'($urandom_range(0, 1));
         ev       = ($urandom_range(0, 3) == 0);
         sel_ev   = ($urandom_range(0, 7) == 0) ? ~sel_ev : sel_ev;
         run      = ($urandom_range(0, 9) != 0);
         gate_en  = ($urandom_range(0, 3) == 0);
         gate_pin = 1'($urandom_range(0, 1));
         run_hi   = ($urandom_range(0, 3) != 0);
         wr_lo    = ($urandom_range(0, 15) == 0);
         wr_hi    = ($urandom_range(0, 15) == 0);
         wdata    = BW'($urandom_range(240, 255));
         clr      = ($urandom_range(0, 7) == 0);
         clr_hi   = ($urandom_range(0, 7) == 0);
         cyc("R2 R9 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule